// File: doc/BRIEF.md
# Delay-Line Time-to-Digital Edge Encoder

This block sits right after the flip-flop row of an inverter delay chain in a digital phase-locked loop. On every reference-clock edge it receives the sampled state of the chain, one bit per tap, together with a strobe that marks a sample as valid. From that vector it produces an unsigned phase-error code, one LSB per inverter delay, for the loop filter.

Successive inverter outputs alternate in polarity. The encoder therefore first flips every odd-indexed tap. This gives a thermometer-like vector in which taps already passed by the edge read 1. It then looks for the first 1-to-0 step in that vector. A lone 0 that sits between ones is treated as a sampling bubble and skipped. The position of the step becomes the code. When no step exists, or when the position exceeds what the code width can hold, the code pins at its all-ones maximum and a saturation flag is raised. The code width is chosen so that the locked-state phase swing caused by the fractional modulator fits inside the range.

The result is registered once and appears with a valid flag one clock after the strobe.

Top module: `tdc_edge_encoder`

## Requirements
- R1: After reset, and until the first strobed sample, outValid, phaseCode and saturated are all 0.
- R2: Before detection, each tap at an odd index i is inverted and each even-indexed tap is kept, giving the normalized bit n[i] = taps[i] XOR i[0].
- R3: phaseCode equals the lowest index i (1 ≤ i ≤ NUM_TAPS−1) where n[i−1]=1, n[i]=0, and either i is the last tap or n[i+1]=0. The code is therefore never 0 for a valid sample.
- R4: A single 0 with 1 on both sides in the normalized vector (n[i−1]=1, n[i]=0, n[i+1]=1) is not taken as the edge, and the search moves on to higher indices.
- R5: When no index satisfies R3, phaseCode is 2^CODE_W−1 and saturated is 1.
- R6: When an index satisfying R3 exists and is at most 2^CODE_W−1, saturated is 0.
- R7: A sample taken on a clock edge with sampleValid high sets outValid high, with its code and flag, right after that same edge. A sample taken with sampleValid low leaves outValid low after that edge.
- R8: While sampleValid is low, phaseCode and saturated keep their previous values whatever the taps carry.
- R9: An edge found at an index above 2^CODE_W−1 yields phaseCode 2^CODE_W−1 with saturated 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks taps as a fresh sample |
| taps | input | NUM_TAPS | Raw delay-chain flip-flop samples, index 0 nearest the chain input |
| outValid | output | 1 | Code and flag belong to the sample strobed on the previous edge |
| phaseCode | output | CODE_W | Unsigned edge position, one LSB per inverter delay |
| saturated | output | 1 | No edge found, or edge beyond the code range |

## Verification
A wrong polarity mask or a faulty bubble rule shows as a wrong phaseCode on the very next clock after the offending sample. The bench applies every possible tap vector of a 12-tap, 3-bit configuration, so each such fault appears at the ports. A broken clamp shows as a code that wraps instead of pinning, or as a missing or spurious saturation flag, also one cycle later. A control fault shows as outValid being out of step with the strobe, or as the code changing during idle cycles.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new code/flag this edge
  } encStrobe_t;
endpackage

// File: rtl/tdc_enc_ctrl.sv
module tdc_enc_ctrl
  import tdc_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  output encStrobe_t strobe,
  output logic       validQ
);
  always_comb begin
    strobe.load = sampleValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= sampleValid;
  end
endmodule

// File: rtl/tdc_enc_datapath.sv
module tdc_enc_datapath
  import tdc_enc_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  parameter int CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  encStrobe_t          strobe,
  input  logic [NUM_TAPS-1:0] taps,
  output logic [CODE_W-1:0]   codeQ,
  output logic                satQ
);
  localparam int IDX_W    = $clog2(NUM_TAPS);
  localparam int WIDE_W   = ((IDX_W > CODE_W) ? IDX_W : CODE_W) + 1;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  logic [NUM_TAPS-1:0] normBits;
  logic [NUM_TAPS-1:0] hitBits;

  // polarity undo and per-position edge test
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    if (i % 2 == 1) begin : g_odd
      assign normBits[i] = ~taps[i];
    end else begin : g_even
      assign normBits[i] = taps[i];
    end

    if (i == 0) begin : g_first
      assign hitBits[i] = 1'b0;
    end else if (i == NUM_TAPS - 1) begin : g_last
      assign hitBits[i] = normBits[i-1] & ~normBits[i];
    end else begin : g_mid
      // a 0 followed by a 1 is a bubble, not the edge
      assign hitBits[i] = normBits[i-1] & ~normBits[i] & ~normBits[i+1];
    end
  end

  logic             found;
  logic [IDX_W-1:0] edgePos;

  always_comb begin
    found   = 1'b0;
    edgePos = '0;
    for (int i = NUM_TAPS - 1; i >= 0; i--) begin
      if (hitBits[i]) begin
        found   = 1'b1;
        edgePos = IDX_W'(i);
      end
    end
  end

  logic [WIDE_W-1:0] posWide;
  logic              overRange;
  logic              satNext;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    posWide   = WIDE_W'(edgePos);
    overRange = posWide > WIDE_W'(MAX_CODE);
    satNext   = !found || overRange;
    codeNext  = satNext ? CODE_W'(MAX_CODE) : CODE_W'(edgePos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      satQ  <= 1'b0;
    end else if (strobe.load) begin
      codeQ <= codeNext;
      satQ  <= satNext;
    end
  end
endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder
  import tdc_enc_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  parameter int CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [NUM_TAPS-1:0] taps,
  output logic                outValid,
  output logic [CODE_W-1:0]   phaseCode,
  output logic                saturated
);
  encStrobe_t strobe;

  tdc_enc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .validQ     (outValid)
  );

  tdc_enc_datapath #(
    .NUM_TAPS(NUM_TAPS),
    .CODE_W  (CODE_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .taps  (taps),
    .codeQ (phaseCode),
    .satQ  (saturated)
  );
endmodule

// File: rtl/tdc_edge_encoder_chk.sv
module tdc_edge_encoder_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              outValid,
  input logic [CODE_W-1:0] phaseCode,
  input logic              saturated
);
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);

  // R7
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(phaseCode) && $stable(saturated)));

  // R5
  sat_pins_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    saturated |-> phaseCode == MAX_CODE);

  // R3
  nonzero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> phaseCode != '0);

  // R6
  in_range_no_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && phaseCode != MAX_CODE) |-> !saturated);
endmodule

bind tdc_edge_encoder tdc_edge_encoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .outValid   (outValid),
  .phaseCode  (phaseCode),
  .saturated  (saturated)
);

// File: tb/tdc_edge_encoder_test.sv
module tdc_edge_encoder_test;
  localparam int NT     = 12;
  localparam int CW     = 3;
  localparam int MAXC   = (1 << CW) - 1;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [NT-1:0] taps = '0;
  logic          outValid;
  logic [CW-1:0] phaseCode;
  logic          saturated;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  tdc_edge_encoder #(.NUM_TAPS(NT), .CODE_W(CW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .taps(taps),
    .outValid(outValid), .phaseCode(phaseCode), .saturated(saturated)
  );

  // reference model: returns edge index, 0 when none; kind tags the case
  function automatic int refEdge(input int raw, output string kind);
    int bits[NT];
    kind = "R3";
    for (int k = 0; k < NT; k++) bits[k] = ((raw >> k) & 1) ^ (k % 2);
    for (int k = 1; k < NT; k++) begin
      if (bits[k-1] == 1 && bits[k] == 0) begin
        if (k < NT - 1 && bits[k+1] == 1) begin
          kind = "R4";
          continue;
        end
        if (k > MAXC) kind = "R9";
        return k;
      end
    end
    kind = "R5";
    return 0;
  endfunction

  task automatic checkOut(input bit expV, input int expC, input bit expS, input string tag);
    vecCount++;
    if (outValid !== expV || phaseCode !== CW'(expC) || saturated !== expS) begin
      errCount++;
      $display("FAIL %s: got v=%0b code=%0d sat=%0b, expected v=%0b code=%0d sat=%0b",
               tag, outValid, phaseCode, saturated, expV, expC, expS);
    end
  endtask

  task automatic expectFor(input int raw, input string forceTag);
    string kind;
    int e;
    int c;
    bit s;
    e = refEdge(raw, kind);
    if (e == 0 || e > MAXC) begin c = MAXC; s = 1'b1; end
    else begin c = e; s = 1'b0; end
    checkOut(1'b1, c, s, (forceTag != "") ? forceTag : kind);
  endtask

  initial begin
    int lastCode;
    bit lastSat;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOut(1'b0, 0, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 0, 1'b0, "R1");

    // R2: directed polarity case, normalized 111000000000 -> edge 3
    taps = 12'hAAD;
    sampleValid = 1'b1;
    @(negedge clk);
    expectFor(12'hAAD, "R2");

    // exhaustive sweep, one vector per cycle
    for (int v = 0; v < (1 << NT); v++) begin
      taps = NT'(v);
      sampleValid = 1'b1;
      @(negedge clk);
      expectFor(v, "");
    end

    // R8: idle cycles keep code and flag, R7: valid drops
    lastCode = int'(phaseCode);
    lastSat  = saturated;
    sampleValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      taps = NT'(12'h0F0 + k * 37);
      @(negedge clk);
      checkOut(1'b0, lastCode, lastSat, "R8");
    end

    // R7: a single strobe after idle
    taps = 12'h001;   // normalized bit0=1, bit1=1, rest alternate -> model decides
    sampleValid = 1'b1;
    @(negedge clk);
    expectFor(12'h001, "R7");
    sampleValid = 1'b0;
    @(negedge clk);
    checkOut(1'b0, lastCodeOf(12'h001), lastSatOf(12'h001), "R7");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  function automatic int lastCodeOf(input int raw);
    string kind;
    int e;
    e = refEdge(raw, kind);
    return (e == 0 || e > MAXC) ? MAXC : e;
  endfunction

  function automatic bit lastSatOf(input int raw);
    string kind;
    int e;
    e = refEdge(raw, kind);
    return (e == 0 || e > MAXC);
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule